// File: doc/BRIEF.md
# Temperature Sensor Limit and Alarm Logic

This block is the digital core of a memory-module temperature sensor. A simple register bus (3-bit address, 16-bit write data, write strobe, combinational read data) reaches eight 16-bit registers. These hold a capability word, a configuration word, three limit registers (upper, lower, critical), the live temperature, and two identity words. A converter model delivers 13-bit two's complement samples at 0.0625 °C per LSB through a valid strobe.

Each accepted sample is stored and compared with the three limits. The comparison applies a hysteresis band that the configuration selects with a 2-bit code. The three resulting alarm flags are packed into the top bits of the temperature register. An event output summarises them, either as all three alarms or as the critical alarm alone. Two lock bits protect the limits and the hysteresis setting, and a shutdown bit freezes the temperature and alarm state.

Top module: `tsl_core`

## Requirements
- R1: After reset the configuration, all three limits and the temperature register read 0x0000 and `evt` is low. The addresses are 0 capability, 1 configuration, 2 upper limit, 3 lower limit, 4 critical limit, 5 temperature, 6 manufacturer ID and 7 device ID, and the two ID registers return the parameters `MFR_ID` and `DEV_ID`.
- R2: A limit write stores bits 12:0 of the write data as a 13-bit two's complement value. Reading the limit returns that value in bits 12:0 with bits 15:13 zero.
- R3: A sample taken while `smp_valid` is high and shutdown is clear appears in temperature bits 12:0 one clock later. Bit 15 carries the critical alarm, bit 14 the above-upper alarm and bit 13 the below-lower alarm, all updated on that same sample.
- R4: The above-upper alarm and the critical alarm set on a sample strictly greater than their limit. Once set, each clears only on a sample less than or equal to its limit minus the hysteresis.
- R5: The below-lower alarm sets on a sample strictly less than the lower limit. Once set, it clears only on a sample greater than or equal to the lower limit plus the hysteresis.
- R6: Configuration bits 10:9 select the hysteresis. Codes 0, 1, 2 and 3 give 0, 24, 48 and 96 LSB (0, 1.5, 3 and 6 °C).
- R7: While configuration bit 8 (shutdown) is set, samples are ignored, and the temperature value and all alarm flags hold.
- R8: While configuration bit 7 is set, writes to the upper and lower limits are ignored. While bit 6 is set, writes to the critical limit are ignored. An unlocked limit still accepts writes.
- R9: If bit 7 or bit 6 is set before a configuration write, that write leaves bits 10:9 unchanged and updates the other writable bits.
- R10: Configuration bits 15:11 always read zero. The capability register reads bits 15:8 as zero, bits 1:0 as one, and bit 2 as the `EXT_RANGE` parameter.
- R11: Writes to the capability, temperature, manufacturer ID and device ID addresses change nothing.
- R12: With configuration bit 2 set, `evt` follows the critical alarm only. With it clear, `evt` is the OR of all three alarms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| smp_valid | input | 1 | New temperature sample present |
| smp_temp | input | 13 | Sample, two's complement, 0.0625 °C per LSB |
| evt | output | 1 | Event output derived from the alarm flags |

## Verification
The hardest state to reach is an alarm that sits inside its hysteresis band: it has set, the temperature has fallen back past the limit, and it has not yet cleared. The state can only be seen if the temperature approaches from the right side with the right hysteresis code active. The bench ramps the sample one LSB at a time across all three limits, including a negative lower limit, first upward and then downward. It repeats the ramp for every hysteresis code in both event modes, so every set and clear edge is hit exactly. The locked-hysteresis case needs a configuration write made while a lock is already set, so the bench sets a lock, then attempts a new code, then clears the lock.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 3;
    localparam int TEMP_W       = 13;
    localparam int XW           = TEMP_W + 2;   // widened signed compare width
    localparam int N_LIM        = 3;
    localparam int CFG_USED_W   = 11;           // bits 10:0 writable
    localparam int HALF_DEG_LSB = 8;            // 0.5 C at 0.0625 C/LSB

    localparam int LIM_HIGH = 0;
    localparam int LIM_LOW  = 1;
    localparam int LIM_CRIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_CAP  = 3'd0,
        RA_CFG  = 3'd1,
        RA_HIGH = 3'd2,
        RA_LOW  = 3'd3,
        RA_CRIT = 3'd4,
        RA_TEMP = 3'd5,
        RA_MFR  = 3'd6,
        RA_DEV  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [4:0] rsv;        // 15:11
        logic [1:0] hyst;       // 10:9
        logic       shdn;       // 8
        logic       evt_lock;   // 7
        logic       crit_lock;  // 6
        logic [2:0] spare_hi;   // 5:3
        logic       crit_only;  // 2
        logic [1:0] spare_lo;   // 1:0
    } cfg_t;

    localparam logic [DATA_W-1:0] CFG_WMASK = DATA_W'((1 << CFG_USED_W) - 1);

    function automatic reg_addr_e lim_addr(input int idx);
        case (idx)
            LIM_HIGH: return RA_HIGH;
            LIM_LOW:  return RA_LOW;
            default:  return RA_CRIT;
        endcase
    endfunction

    function automatic logic signed [XW-1:0] sx(input logic [TEMP_W-1:0] v);
        return $signed({{(XW-TEMP_W){v[TEMP_W-1]}}, v});
    endfunction

    function automatic logic signed [XW-1:0] hyst_lsb(input logic [1:0] code);
        case (code)
            2'd0:    return '0;
            2'd1:    return XW'(3 * HALF_DEG_LSB);
            2'd2:    return XW'(6 * HALF_DEG_LSB);
            default: return XW'(12 * HALF_DEG_LSB);
        endcase
    endfunction

endpackage

// File: rtl/tsl_cfg_regs.sv
module tsl_cfg_regs
    import tsl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output cfg_t                          cfg_q,
    output logic [N_LIM-1:0][TEMP_W-1:0]  lim_q
);

    logic any_lock;
    cfg_t cfg_nx;

    assign any_lock = cfg_q.evt_lock | cfg_q.crit_lock;

    always_comb begin
        cfg_nx = cfg_t'(wdata & CFG_WMASK);
        if (any_lock) begin
            cfg_nx.hyst = cfg_q.hyst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we && (addr == RA_CFG)) begin
            cfg_q <= cfg_nx;
        end
    end

    for (genvar i = 0; i < N_LIM; i++) begin : g_lim
        logic locked;
        logic hit;

        if (i == LIM_CRIT) begin : g_crit
            assign locked = cfg_q.crit_lock;
        end else begin : g_evt
            assign locked = cfg_q.evt_lock;
        end

        assign hit = we && (addr == lim_addr(i)) && !locked;

        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[i] <= '0;
            end else if (hit) begin
                lim_q[i] <= wdata[TEMP_W-1:0];
            end
        end
    end

endmodule

// File: rtl/tsl_limit_cmp.sv
module tsl_limit_cmp
    import tsl_pkg::*;
#(
    parameter bit ABOVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] limit,
    input  logic [1:0]        hyst_code,
    output logic              flag
);

    logic signed [XW-1:0] t_s;
    logic signed [XW-1:0] l_s;
    logic signed [XW-1:0] h_s;
    logic                 nxt;

    assign t_s = sx(temp);
    assign l_s = sx(limit);
    assign h_s = hyst_lsb(hyst_code);

    if (ABOVE) begin : g_above
        always_comb begin
            if (flag) nxt = t_s > (l_s - h_s);
            else      nxt = t_s > l_s;
        end
    end else begin : g_below
        always_comb begin
            if (flag) nxt = t_s < (l_s + h_s);
            else      nxt = t_s < l_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (upd) begin
            flag <= nxt;
        end
    end

endmodule

// File: rtl/tsl_temp_track.sv
module tsl_temp_track
    import tsl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          smp_valid,
    input  logic [TEMP_W-1:0]             smp_temp,
    input  logic                          shdn,
    input  logic [1:0]                    hyst_code,
    input  logic [N_LIM-1:0][TEMP_W-1:0]  lim_q,
    output logic [TEMP_W-1:0]             temp_q,
    output logic [N_LIM-1:0]              alm_q
);

    logic take;

    assign take = smp_valid && !shdn;

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
        end else if (take) begin
            temp_q <= smp_temp;
        end
    end

    for (genvar i = 0; i < N_LIM; i++) begin : g_cmp
        tsl_limit_cmp #(
            .ABOVE (i != LIM_LOW)
        ) u_cmp (
            .clk       (clk),
            .rst       (rst),
            .upd       (take),
            .temp      (smp_temp),
            .limit     (lim_q[i]),
            .hyst_code (hyst_code),
            .flag      (alm_q[i])
        );
    end

endmodule

// File: rtl/tsl_core.sv
module tsl_core
    import tsl_pkg::*;
#(
    parameter logic [15:0] MFR_ID    = 16'h1A2B,
    parameter logic [15:0] DEV_ID    = 16'h0C01,
    parameter bit          EXT_RANGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    output logic [15:0]       bus_rdata,
    input  logic              smp_valid,
    input  logic [12:0]       smp_temp,
    output logic              evt
);

    localparam logic [DATA_W-1:0] CAP_WORD = DATA_W'({EXT_RANGE, 2'b11});
    localparam int                PAD_W    = DATA_W - TEMP_W;

    cfg_t                         cfg_q;
    logic [N_LIM-1:0][TEMP_W-1:0] lim_q;
    logic [TEMP_W-1:0]            temp_q;
    logic [N_LIM-1:0]             alm_q;

    tsl_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cfg_q (cfg_q),
        .lim_q (lim_q)
    );

    tsl_temp_track u_track (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_temp  (smp_temp),
        .shdn      (cfg_q.shdn),
        .hyst_code (cfg_q.hyst),
        .lim_q     (lim_q),
        .temp_q    (temp_q),
        .alm_q     (alm_q)
    );

    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_CAP:  bus_rdata = CAP_WORD;
            RA_CFG:  bus_rdata = cfg_q;
            RA_HIGH: bus_rdata = {{PAD_W{1'b0}}, lim_q[LIM_HIGH]};
            RA_LOW:  bus_rdata = {{PAD_W{1'b0}}, lim_q[LIM_LOW]};
            RA_CRIT: bus_rdata = {{PAD_W{1'b0}}, lim_q[LIM_CRIT]};
            RA_TEMP: bus_rdata = {alm_q[LIM_CRIT], alm_q[LIM_HIGH], alm_q[LIM_LOW], temp_q};
            RA_MFR:  bus_rdata = MFR_ID;
            default: bus_rdata = DEV_ID;
        endcase
    end

    assign evt = cfg_q.crit_only ? alm_q[LIM_CRIT] : (|alm_q);

endmodule

// File: rtl/tsl_core_chk.sv
module tsl_core_chk
    import tsl_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          bus_we,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          smp_valid,
    input logic                          shdn,
    input logic                          evt_lock,
    input logic                          crit_lock,
    input logic [1:0]                    hyst,
    input logic [N_LIM-1:0][TEMP_W-1:0]  lim_q,
    input logic [TEMP_W-1:0]             temp_q,
    input logic [N_LIM-1:0]              alm_q
);

    // R3: state moves only on an accepted sample
    p_no_sample_r3: assert property (@(posedge clk) disable iff (rst)
        !(smp_valid && !shdn) |=> ($stable(temp_q) && $stable(alm_q)));

    // R7: shutdown freezes temperature and alarms
    p_shdn_hold_r7: assert property (@(posedge clk) disable iff (rst)
        shdn |=> ($stable(temp_q) && $stable(alm_q)));

    // R8: event lock blocks upper and lower limit writes
    p_evt_lock_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && evt_lock && (bus_addr == RA_HIGH || bus_addr == RA_LOW))
        |=> $stable(lim_q));

    // R8: critical lock blocks critical limit writes
    p_crit_lock_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && crit_lock && bus_addr == RA_CRIT) |=> $stable(lim_q));

    // R9: any lock keeps the hysteresis code
    p_hyst_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (evt_lock || crit_lock) && bus_addr == RA_CFG) |=> $stable(hyst));

    // R11: writes to read-only addresses leave limits untouched
    p_ro_write_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == RA_CAP || bus_addr == RA_TEMP ||
                    bus_addr == RA_MFR || bus_addr == RA_DEV)) |=> $stable(lim_q));

endmodule

bind tsl_core tsl_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .smp_valid (smp_valid),
    .shdn      (cfg_q.shdn),
    .evt_lock  (cfg_q.evt_lock),
    .crit_lock (cfg_q.crit_lock),
    .hyst      (cfg_q.hyst),
    .lim_q     (lim_q),
    .temp_q    (temp_q),
    .alm_q     (alm_q)
);

// File: tb/sim_tsl_core.sv
`timescale 1ns/1ps
module sim_tsl_core;

    localparam logic [15:0] MFR = 16'h1A2B;
    localparam logic [15:0] DEV = 16'h0C01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        smp_valid = 1'b0;
    logic [12:0] smp_temp = '0;
    logic        evt;

    int checks = 0;
    int failures = 0;

    // model state
    logic [15:0] m_cfg = '0;
    int          m_lim [3];
    logic        m_hi = 0, m_lo = 0, m_cr = 0;
    logic [12:0] m_t = '0;

    always #4 clk = ~clk;

    tsl_core #(.MFR_ID(MFR), .DEV_ID(DEV), .EXT_RANGE(1'b1)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
        .smp_temp(smp_temp), .evt(evt)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic int hv(input logic [1:0] c);
        case (c)
            2'd0: return 0;
            2'd1: return 24;
            2'd2: return 48;
            default: return 96;
        endcase
    endfunction

    function automatic logic [15:0] exp_temp();
        return {m_cr, m_hi, m_lo, m_t};
    endfunction

    function automatic logic exp_evt();
        return m_cfg[2] ? m_cr : (m_cr | m_hi | m_lo);
    endfunction

    // configuration write with model of the lock rule (R9, R10)
    task automatic wr_cfg(input logic [15:0] d, input string req);
        logic [15:0] e, r;
        e = d & 16'h07FF;
        if (m_cfg[7] || m_cfg[6]) e[10:9] = m_cfg[10:9];
        m_cfg = e;
        wr(3'd1, d);
        rd(3'd1, r);
        chk(req, r, e);
    endtask

    // limit write: idx 0 upper, 1 lower, 2 critical (R2, R8)
    task automatic wr_lim(input int idx, input int v, input string req);
        logic [15:0] r;
        logic        locked;
        logic [15:0] vw;
        vw = 16'(v);
        locked = (idx == 2) ? m_cfg[6] : m_cfg[7];
        if (!locked) m_lim[idx] = v;
        wr(3'(idx + 2), vw);
        rd(3'(idx + 2), r);
        chk(req, r, {3'b000, 13'(m_lim[idx])});
    endtask

    task automatic sample(input int t, input string req);
        logic [15:0] r;
        int h;
        @(negedge clk);
        smp_temp = 13'(t); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        if (!m_cfg[8]) begin
            h = hv(m_cfg[10:9]);
            m_hi = m_hi ? (t > m_lim[0] - h) : (t > m_lim[0]);
            m_cr = m_cr ? (t > m_lim[2] - h) : (t > m_lim[2]);
            m_lo = m_lo ? (t < m_lim[1] + h) : (t < m_lim[1]);
            m_t  = 13'(t);
        end
        rd(3'd5, r);
        chk(req, r, exp_temp());
        chk({req, " evt R12"}, {15'd0, evt}, {15'd0, exp_evt()});
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] r;
        m_lim[0] = 0; m_lim[1] = 0; m_lim[2] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R10: reset state and constants
        rd(3'd0, r); chk("R10 cap", r, 16'h0007);
        rd(3'd1, r); chk("R1 cfg", r, 16'h0000);
        rd(3'd2, r); chk("R1 upper", r, 16'h0000);
        rd(3'd3, r); chk("R1 lower", r, 16'h0000);
        rd(3'd4, r); chk("R1 crit", r, 16'h0000);
        rd(3'd5, r); chk("R1 temp", r, 16'h0000);
        rd(3'd6, r); chk("R1 mfr", r, MFR);
        rd(3'd7, r); chk("R1 dev", r, DEV);
        chk("R1 evt", {15'd0, evt}, 16'h0000);

        // R2: limits including a negative lower limit
        wr_lim(0, 400, "R2 upper");
        wr_lim(1, -40, "R2 lower negative");
        wr_lim(2, 480, "R2 crit");

        // R3 R4 R5 R6 R12: single-LSB ramps for every code and event mode
        for (int co = 0; co < 2; co++) begin
            for (int h = 0; h < 4; h++) begin
                wr_cfg(16'((h << 9) | (co << 2)), "R6 cfg hyst");
                for (int t = -140; t <= 580; t++) sample(t, "R4 R5 ramp up");
                for (int t = 580; t >= -140; t--) sample(t, "R4 R5 ramp down");
            end
        end

        // R7: shutdown holds temperature and alarms
        wr_cfg(16'h0100, "R7 cfg shdn");
        sample(500, "R7 shutdown hold");
        sample(-300, "R7 shutdown hold");
        wr_cfg(16'h0000, "R7 cfg wake");
        sample(500, "R3 after wake");

        // R8 R9: event lock
        wr_cfg(16'h0280, "R9 lock set with new hyst");
        wr_lim(0, 100, "R8 upper locked");
        wr_lim(1, 7, "R8 lower locked");
        wr_lim(2, 300, "R8 crit unlocked");
        wr_cfg(16'h0684, "R9 hyst kept under event lock");
        wr_cfg(16'h0000, "R9 unlock keeps hyst");
        wr_cfg(16'h0000, "R9 hyst clears once unlocked");

        // R8 R9: critical lock
        wr_cfg(16'h0040, "R8 crit lock set");
        wr_lim(2, 50, "R8 crit locked");
        wr_lim(0, 350, "R8 upper unlocked");
        wr_cfg(16'h0640, "R9 hyst kept under crit lock");
        wr_cfg(16'h0000, "R9 unlock");
        wr_cfg(16'h0000, "R9 clear");
        sample(360, "R4 new limits");
        sample(320, "R4 new limits");

        // R10: reserved configuration bits
        wr_cfg(16'hFFFF, "R10 cfg reserved zero");
        wr_cfg(16'h0000, "R10 cfg unlock");
        wr_cfg(16'h0000, "R10 cfg clear");

        // R11: read-only registers ignore writes
        wr(3'd0, 16'hFFFF); rd(3'd0, r); chk("R11 cap", r, 16'h0007);
        wr(3'd5, 16'h1234); rd(3'd5, r); chk("R11 temp", r, exp_temp());
        wr(3'd6, 16'h0000); rd(3'd6, r); chk("R11 mfr", r, MFR);
        wr(3'd7, 16'hFFFF); rd(3'd7, r); chk("R11 dev", r, DEV);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule